// File: doc/BRIEF.md
# Programmable Chip Select Decoder

This block turns the address of each bus transfer into one of eight active-low chip selects, or into a "default region" when no bank claims the address. Software sets up each bank through a small register port. A bank has a base register, a mask register and a control register. The base and mask registers cover the upper sixteen transfer address bits. The mask register also holds the bank's enable bit. The control register gives port width, burst permission, a wait-state count and an automatic-acknowledge switch. A ninth control register describes the default region.

When a transfer starts, the block compares the upper address bits with every enabled bank, ignoring the masked bits. The lowest-numbered matching bank wins. The block then latches that bank's select and attributes for the whole transfer and counts the programmed wait states. It then gives a one-cycle transfer acknowledge. When automatic acknowledge is switched off, it instead waits for an external acknowledge. Out of reset, bank 0 answers every ordinary address so that boot code can be fetched from anywhere. Bank 1 can optionally claim CPU-space and interrupt-acknowledge cycles.

The transfer sequencer has four states. IDLE waits for a start. COUNT decrements the wait counter. ACK drives the acknowledge for one cycle. EXTWAIT holds the select until the external acknowledge arrives. The transitions are as follows:
- IDLE to ACK on a start whose bank has automatic acknowledge and zero wait states.
- IDLE to COUNT on a start with automatic acknowledge and a nonzero wait count.
- IDLE to EXTWAIT on a start without automatic acknowledge.
- COUNT to ACK when the counter reaches zero.
- ACK to IDLE always.
- EXTWAIT to IDLE on the external acknowledge.

Top module: `chip_select_decoder`

## Requirements
- R1: After reset, all selects are high and the acknowledge is low. Bank 0 is enabled (mask register reads 0x0000_0001) and its control reads 0x0000_00F8. The default control reads 0x0000_00F8. Every other bank reads zero.
- R2: Register address bits [5:2] pick the bank (0..7), or the default control at index 8. Bits [1:0] pick the register: 0 base, 1 mask, 2 control. The base and mask fields sit in data bits [31:16], the enable bit in mask bit 0, and the control in bits [8:0] as {cpu_space_en, auto_ack, wait[3:0], burst, port[1:0]}. Written values read back.
- R3: An ordinary transfer hits an enabled bank when the transfer address bits [31:16] equal the base on every bit whose mask bit is 0. Address bits [15:0] are ignored.
- R4: Until the first write to bank 0's base register, bank 0 hits every ordinary transfer. After that write, it decodes like any other bank.
- R5: A bank whose enable bit is 0 never hits.
- R6: When several banks hit, only the lowest-numbered one asserts its select.
- R7: A CPU-space transfer hits only bank 1, and only when bank 1 is enabled and its cpu_space_en bit is 1. Otherwise it falls to the default region.
- R8: A transfer that hits no bank raises dflt_hit and leaves all selects high. It takes its port width, burst and wait count from the default control.
- R9: While a transfer runs, port_size and burst_en show the selected bank's settings. With automatic acknowledge set and wait count N, xfer_ack is high for exactly one cycle, N cycles after the first cycle of the transfer. The select is released in the cycle after the acknowledge.
- R10: With automatic acknowledge clear, xfer_ack stays low and the select is held until ext_ack is sampled high. The block is idle in the next cycle.
- R11: A start pulse seen while a transfer is running is ignored. It neither changes the select nor shifts the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index: bank in [5:2], register kind in [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| xfer_start | input | 1 | One-cycle pulse that begins a transfer |
| xfer_addr | input | 32 | Transfer address, sampled with xfer_start |
| xfer_cpu_space | input | 1 | Transfer is a CPU-space or interrupt-acknowledge cycle |
| ext_ack | input | 1 | External acknowledge for banks without automatic acknowledge |
| cs_n | output | 8 | Active-low chip selects |
| port_size | output | 2 | Port width of the current transfer |
| burst_en | output | 1 | Burst permission of the current transfer |
| dflt_hit | output | 1 | Current transfer uses the default region |
| xfer_ack | output | 1 | One-cycle automatic transfer acknowledge |

## Verification
The assertions assume that xfer_start is a single-cycle pulse. They also assume that ext_ack is raised only while a transfer without automatic acknowledge is waiting for it. The bench honours both: every start is driven for exactly one clock, and ext_ack is pulsed only after the bench has confirmed that the acknowledge stayed low for a manual bank. Register writes are made only while no transfer runs, except where R11 deliberately pulses start mid-transfer. This keeps the bench's model of the register contents exact at every start.

// File: rtl/csd_pkg.sv
package csd_pkg;

    localparam int WAIT_W  = 4;
    localparam int PSIZE_W = 2;

    typedef struct packed {
        logic              cpu_en;
        logic              auto_ack;
        logic [WAIT_W-1:0] wait_n;
        logic              burst;
        logic [PSIZE_W-1:0] psize;
    } bank_ctrl_t;

    localparam int CTRL_W = $bits(bank_ctrl_t);

    typedef enum logic [1:0] {
        KIND_BASE = 2'd0,
        KIND_MASK = 2'd1,
        KIND_CTRL = 2'd2,
        KIND_NONE = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_ACK,
        ST_EXTWAIT
    } xfer_state_e;

    localparam bank_ctrl_t BOOT_CTRL = '{
        cpu_en:   1'b0,
        auto_ack: 1'b1,
        wait_n:   '1,
        burst:    1'b0,
        psize:    '0
    };

endpackage

// File: rtl/csd_regs.sv
module csd_regs
    import csd_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int REG_AW = 6,
    parameter int DATA_W = 32,
    parameter int CMP_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [REG_AW-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic [NBANK-1:0][CMP_W-1:0]   base_o,
    output logic [NBANK-1:0][CMP_W-1:0]   mask_o,
    output logic [NBANK-1:0]              valid_o,
    output bank_ctrl_t [NBANK-1:0]        ctrl_o,
    output bank_ctrl_t                    dctrl_o,
    output logic                          glob_o
);

    localparam int IDX_W  = REG_AW - 2;
    localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam logic [IDX_W-1:0] DFLT_IDX = IDX_W'(NBANK);

    logic [IDX_W-1:0] idx;
    reg_kind_e        kind;
    logic             unused_bits;

    assign idx  = addr[REG_AW-1:2];
    assign kind = reg_kind_e'(addr[1:0]);
    assign unused_bits = ^wdata[DATA_W-CMP_W-1:CTRL_W];

    // per-bank storage
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(b);
        logic [CMP_W-1:0] base_q;
        logic [CMP_W-1:0] mask_q;
        logic             valid_q;
        bank_ctrl_t       ctrl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q  <= '0;
                mask_q  <= '0;
                valid_q <= (b == 0);
                ctrl_q  <= (b == 0) ? BOOT_CTRL : bank_ctrl_t'('0);
            end else if (we && idx == MY_IDX) begin
                unique case (kind)
                    KIND_BASE: base_q <= wdata[DATA_W-1 -: CMP_W];
                    KIND_MASK: begin
                        mask_q  <= wdata[DATA_W-1 -: CMP_W];
                        valid_q <= wdata[0];
                    end
                    KIND_CTRL: ctrl_q <= bank_ctrl_t'(wdata[CTRL_W-1:0]);
                    default:   ;
                endcase
            end
        end

        assign base_o[b]  = base_q;
        assign mask_o[b]  = mask_q;
        assign valid_o[b] = valid_q;
        assign ctrl_o[b]  = ctrl_q;
    end

    // default-region control and boot-global flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dctrl_o <= BOOT_CTRL;
            glob_o  <= 1'b1;
        end else if (we) begin
            if (idx == DFLT_IDX && kind == KIND_CTRL)
                dctrl_o <= bank_ctrl_t'(wdata[CTRL_W-1:0]);
            if (idx == '0 && kind == KIND_BASE)
                glob_o <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        rdata = '0;
        if (idx < DFLT_IDX) begin
            unique case (kind)
                KIND_BASE: rdata[DATA_W-1 -: CMP_W] = base_o[idx[BSEL_W-1:0]];
                KIND_MASK: begin
                    rdata[DATA_W-1 -: CMP_W] = mask_o[idx[BSEL_W-1:0]];
                    rdata[0]                 = valid_o[idx[BSEL_W-1:0]];
                end
                KIND_CTRL: rdata[CTRL_W-1:0] = ctrl_o[idx[BSEL_W-1:0]];
                default:   ;
            endcase
        end else if (idx == DFLT_IDX && kind == KIND_CTRL) begin
            rdata[CTRL_W-1:0] = dctrl_o;
        end
    end

    AST_GLOBAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && idx == '0 && kind == KIND_BASE) |=> !glob_o); // R4

endmodule

// File: rtl/csd_match.sv
module csd_match
    import csd_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int CMP_W = 16
) (
    input  logic [CMP_W-1:0]            addr_hi,
    input  logic                        cpu_space,
    input  logic [NBANK-1:0][CMP_W-1:0] base_i,
    input  logic [NBANK-1:0][CMP_W-1:0] mask_i,
    input  logic [NBANK-1:0]            valid_i,
    input  logic                        cpu1_en,
    input  logic                        glob_i,
    output logic [NBANK-1:0]            sel_o,
    output logic                        none_o
);

    logic [NBANK-1:0] raw;

    for (genvar b = 0; b < NBANK; b++) begin : g_cmp
        logic eq;
        assign eq = ((addr_hi ^ base_i[b]) & ~mask_i[b]) == '0;
        if (b == 0) begin : g_boot
            assign raw[b] = !cpu_space && (glob_i || (valid_i[b] && eq));
        end else if (b == 1) begin : g_cpu
            assign raw[b] = valid_i[b] && (cpu_space ? cpu1_en : eq);
        end else begin : g_plain
            assign raw[b] = valid_i[b] && !cpu_space && eq;
        end
    end

    // lowest-numbered hit wins
    assign sel_o  = raw & (~raw + 1'b1);
    assign none_o = (raw == '0);

endmodule

// File: rtl/csd_xfer.sv
module csd_xfer
    import csd_pkg::*;
#(
    parameter int NBANK = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   ext_ack,
    input  logic [NBANK-1:0]       sel_i,
    input  logic                   none_i,
    input  bank_ctrl_t [NBANK-1:0] ctrl_i,
    input  bank_ctrl_t             dctrl_i,
    output logic [NBANK-1:0]       cs_n,
    output logic [PSIZE_W-1:0]     port_size,
    output logic                   burst_en,
    output logic                   dflt_hit,
    output logic                   xfer_ack
);

    xfer_state_e       state, nxt;
    bank_ctrl_t        pick, cur_ctrl;
    logic [NBANK-1:0]  cur_sel;
    logic              cur_dflt;
    logic [WAIT_W-1:0] cnt;
    logic              active;
    logic              unused_bits;

    assign unused_bits = cur_ctrl.cpu_en;

    // attributes of the bank about to be selected
    always_comb begin
        pick = '0;
        for (int b = 0; b < NBANK; b++)
            if (sel_i[b]) pick = bank_ctrl_t'(pick | ctrl_i[b]);
        if (none_i) pick = dctrl_i;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) begin
                if (!pick.auto_ack)        nxt = ST_EXTWAIT;
                else if (pick.wait_n == '0) nxt = ST_ACK;
                else                        nxt = ST_COUNT;
            end
            ST_COUNT:   if (cnt == '0) nxt = ST_ACK;
            ST_ACK:     nxt = ST_IDLE;
            ST_EXTWAIT: if (ext_ack) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register and transfer latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_sel  <= '0;
            cur_ctrl <= '0;
            cur_dflt <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                cur_sel  <= sel_i;
                cur_ctrl <= pick;
                cur_dflt <= none_i;
                cnt      <= pick.wait_n - 1'b1;
            end else if (state == ST_COUNT) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        active    = (state != ST_IDLE);
        cs_n      = active ? ~cur_sel : '1;
        port_size = active ? cur_ctrl.psize : '0;
        burst_en  = active && cur_ctrl.burst;
        dflt_hit  = active && cur_dflt;
        xfer_ack  = (state == ST_ACK);
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R6
    AST_DFLT_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        dflt_hit |-> (&cs_n)); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> !xfer_ack); // R9
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (cnt < cur_ctrl.wait_n)); // R9
    AST_MANUAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXTWAIT) |-> !cur_ctrl.auto_ack); // R10
    AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT || (state == ST_EXTWAIT && !ext_ack)) |=> $stable(cs_n)); // R11

endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
    import csd_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int REG_AW = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int CMP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               xfer_start,
    input  logic [ADDR_W-1:0]  xfer_addr,
    input  logic               xfer_cpu_space,
    input  logic               ext_ack,
    output logic [NBANK-1:0]   cs_n,
    output logic [PSIZE_W-1:0] port_size,
    output logic               burst_en,
    output logic               dflt_hit,
    output logic               xfer_ack
);

    logic [NBANK-1:0][CMP_W-1:0] base_w, mask_w;
    logic [NBANK-1:0]            valid_w, sel_w;
    bank_ctrl_t [NBANK-1:0]      ctrl_w;
    bank_ctrl_t                  dctrl_w;
    logic                        glob_w, none_w;
    logic                        unused_bits;

    assign unused_bits = ^xfer_addr[ADDR_W-CMP_W-1:0];

    csd_regs #(
        .NBANK(NBANK), .REG_AW(REG_AW), .DATA_W(DATA_W), .CMP_W(CMP_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .base_o(base_w), .mask_o(mask_w), .valid_o(valid_w),
        .ctrl_o(ctrl_w), .dctrl_o(dctrl_w), .glob_o(glob_w)
    );

    csd_match #(.NBANK(NBANK), .CMP_W(CMP_W)) u_match (
        .addr_hi(xfer_addr[ADDR_W-1 -: CMP_W]), .cpu_space(xfer_cpu_space),
        .base_i(base_w), .mask_i(mask_w), .valid_i(valid_w),
        .cpu1_en(ctrl_w[1].cpu_en), .glob_i(glob_w),
        .sel_o(sel_w), .none_o(none_w)
    );

    csd_xfer #(.NBANK(NBANK)) u_xfer (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .ext_ack(ext_ack),
        .sel_i(sel_w), .none_i(none_w), .ctrl_i(ctrl_w), .dctrl_i(dctrl_w),
        .cs_n(cs_n), .port_size(port_size), .burst_en(burst_en),
        .dflt_hit(dflt_hit), .xfer_ack(xfer_ack)
    );

endmodule

// File: tb/chip_select_decoder_test.sv
`timescale 1ns/1ps
module chip_select_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_start = 1'b0;
    logic [31:0] xfer_addr = '0;
    logic        xfer_cpu_space = 1'b0;
    logic        ext_ack = 1'b0;
    logic [7:0]  cs_n;
    logic [1:0]  port_size;
    logic        burst_en, dflt_hit, xfer_ack;

    int vectors = 0;
    int errors  = 0;

    // bench model of programmed registers
    logic [15:0] mbase [8];
    logic [15:0] mmask [8];
    logic        mvalid[8];
    logic [8:0]  mctrl [8];
    logic [8:0]  mdctrl;
    logic        mglob;

    always #2.5 clk = ~clk;

    chip_select_decoder uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_start(xfer_start),
        .xfer_addr(xfer_addr), .xfer_cpu_space(xfer_cpu_space), .ext_ack(ext_ack),
        .cs_n(cs_n), .port_size(port_size), .burst_en(burst_en),
        .dflt_hit(dflt_hit), .xfer_ack(xfer_ack)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        summary();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] mk(input bit cpu, input bit aut, input int w, input bit bst, input int ps);
        return {cpu, aut, 4'(w), bst, 2'(ps)};
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    // program a bank and confirm readback (R2)
    task automatic cfg(input int b, input logic [15:0] base, input logic [15:0] mask,
                       input bit vld, input logic [8:0] ctl);
        wr(6'(b*4 + 0), {base, 16'h0});
        wr(6'(b*4 + 1), {mask, 15'h0, vld});
        wr(6'(b*4 + 2), {23'h0, ctl});
        mbase[b] = base; mmask[b] = mask; mvalid[b] = vld; mctrl[b] = ctl;
        if (b == 0) mglob = 1'b0;
        rd_chk(6'(b*4 + 0), {base, 16'h0}, "R2");
        rd_chk(6'(b*4 + 1), {mask, 15'h0, vld}, "R2");
        rd_chk(6'(b*4 + 2), {23'h0, ctl}, "R2");
    endtask

    function automatic int exp_bank(input logic [31:0] a, input bit cpu);
        for (int b = 0; b < 8; b++) begin
            bit eq, hit;
            eq = ((a[31:16] ^ mbase[b]) & ~mmask[b]) == 16'h0;
            if (b == 0)      hit = !cpu && (mglob || (mvalid[0] && eq));
            else if (b == 1) hit = mvalid[1] && (cpu ? mctrl[1][8] : eq);
            else             hit = mvalid[b] && !cpu && eq;
            if (hit) return b;
        end
        return 8;
    endfunction

    task automatic run_xfer(input logic [31:0] a, input bit cpu, input string req);
        int eb, n;
        logic [8:0] ec;
        logic [7:0] ecs;
        eb  = exp_bank(a, cpu);
        ec  = (eb < 8) ? mctrl[eb] : mdctrl;
        ecs = (eb < 8) ? ~(8'h1 << eb) : 8'hFF;
        @(negedge clk);
        xfer_start = 1'b1; xfer_addr = a; xfer_cpu_space = cpu;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(cs_n === ecs, req, {24'h0, cs_n}, {24'h0, ecs});
        chk(dflt_hit === (eb == 8), req, {31'h0, dflt_hit}, {31'h0, eb == 8});
        chk(port_size === ec[1:0] && burst_en === ec[2], "R9",
            {29'h0, burst_en, port_size}, {29'h0, ec[2], ec[1:0]});
        if (ec[7]) begin
            n = 0;
            while (xfer_ack !== 1'b1 && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk(n == int'(ec[6:3]), "R9", n, ec[6:3]);
            @(negedge clk);
            chk(cs_n === 8'hFF && xfer_ack === 1'b0, "R9", {23'h0, xfer_ack, cs_n}, 32'hFF);
        end else begin
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                chk(xfer_ack === 1'b0 && cs_n === ecs, "R10", {23'h0, xfer_ack, cs_n}, {24'h0, ecs});
            end
            ext_ack = 1'b1;
            @(negedge clk);
            ext_ack = 1'b0;
            chk(cs_n === 8'hFF, "R10", {24'h0, cs_n}, 32'hFF);
        end
    endtask

    initial begin
        for (int b = 0; b < 8; b++) begin
            mbase[b] = '0; mmask[b] = '0; mvalid[b] = (b == 0);
            mctrl[b] = (b == 0) ? 9'h0F8 : 9'h0;
        end
        mdctrl = 9'h0F8;
        mglob  = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(cs_n === 8'hFF && xfer_ack === 1'b0, "R1", {23'h0, xfer_ack, cs_n}, 32'hFF);
        rd_chk(6'd1, 32'h0000_0001, "R1");
        rd_chk(6'd2, 32'h0000_00F8, "R1");
        rd_chk(6'd32 + 6'd2, 32'h0000_00F8, "R1");
        rd_chk(6'd12 + 6'd1, 32'h0, "R1");
        rd_chk(6'd12 + 6'd2, 32'h0, "R1");

        // R4 boot-global bank 0, R7 CPU space falls to default
        run_xfer(32'h0000_0000, 1'b0, "R4");
        run_xfer(32'hFFFF_1234, 1'b0, "R4");
        run_xfer(32'h8A5C_0000, 1'b0, "R4");
        run_xfer(32'h0000_0000, 1'b1, "R7");

        // program the map
        mdctrl = mk(0, 1, 4, 1, 2);
        wr(6'd34, {23'h0, mdctrl});
        rd_chk(6'd34, {23'h0, mdctrl}, "R2");
        cfg(0, 16'h0000, 16'h0000, 1, mk(0, 1, 0, 0, 1));
        cfg(1, 16'h0010, 16'h000F, 1, mk(1, 1, 2, 1, 2));
        cfg(2, 16'h0018, 16'h0007, 1, mk(0, 1, 1, 0, 3));
        cfg(3, 16'h0040, 16'h003F, 1, mk(0, 1, 3, 1, 0));
        cfg(4, 16'h0080, 16'h0000, 0, mk(0, 1, 1, 1, 1));
        cfg(5, 16'h00A0, 16'h0001, 1, mk(0, 1, 0, 0, 3));
        cfg(6, 16'h00C0, 16'h0000, 1, mk(0, 0, 0, 1, 1));
        cfg(7, 16'h0042, 16'h0000, 1, mk(0, 1, 5, 0, 2));

        // R4 global mode gone after the base write
        run_xfer(32'h8A5C_0000, 1'b0, "R4");

        // R3 sweep over the low address byte and two top bytes
        for (int t = 0; t < 2; t++)
            for (int h = 0; h < 256; h++)
                run_xfer({(t == 0) ? 8'h00 : 8'h5A, 8'(h), 8'(h), ~8'(h)}, 1'b0, "R3");

        // R6 overlaps, R8 default, R10 manual ack
        run_xfer(32'h0019_0000, 1'b0, "R6");
        run_xfer(32'h0042_FFFF, 1'b0, "R6");
        run_xfer(32'h3300_0000, 1'b0, "R8");
        run_xfer(32'h00C0_0001, 1'b0, "R10");

        // R11 start ignored mid-transfer
        @(negedge clk);
        xfer_start = 1'b1; xfer_addr = 32'h0040_0000;
        @(negedge clk);
        xfer_addr = 32'h00A0_0000;
        chk(cs_n === 8'hF7, "R11", {24'h0, cs_n}, 32'hF7);
        @(negedge clk);
        xfer_start = 1'b0;
        chk(cs_n === 8'hF7 && xfer_ack === 1'b0, "R11", {23'h0, xfer_ack, cs_n}, 32'hF7);
        begin
            int n = 1;
            while (xfer_ack !== 1'b1 && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk(n == 3 && cs_n === 8'hF7, "R11", n, 3);
        end
        @(negedge clk);
        chk(cs_n === 8'hFF, "R11", {24'h0, cs_n}, 32'hFF);
        @(negedge clk);
        chk(cs_n === 8'hFF, "R11", {24'h0, cs_n}, 32'hFF);

        // R7 CPU space to bank 1, then disabled
        run_xfer(32'h1234_5678, 1'b1, "R7");
        mctrl[1] = mk(0, 1, 2, 1, 2);
        wr(6'd6, {23'h0, mctrl[1]});
        run_xfer(32'h1234_5678, 1'b1, "R7");
        run_xfer(32'h0012_0000, 1'b1, "R7");

        // R5 enable gating
        run_xfer(32'h0080_0000, 1'b0, "R5");
        cfg(4, 16'h0080, 16'h0000, 1, mk(0, 1, 1, 1, 1));
        run_xfer(32'h0080_0000, 1'b0, "R5");
        cfg(3, 16'h0040, 16'h003F, 0, mk(0, 1, 3, 1, 0));
        run_xfer(32'h0042_0000, 1'b0, "R5");
        run_xfer(32'h0050_0000, 1'b0, "R5");

        summary();
    end

endmodule